// File: doc/BRIEF.md
# Chainable TDM Output Serializer

This block is the serial output stage of an audio device that can be linked into a time-division-multiplexed chain. On a frame-sync clock it captures one left and one right sample side by side into a single slot register. It then sends that register out, one bit per bit clock. Its serial input comes from the output of the device ahead of it in the chain. Linking the output of each device to the chain input of the next makes one long shift register, which a DSP serial port reads as a single frame. That frame carries one slot of 64 bits per device.

In slave mode both the frame sync and the bit clock come from outside. The frame may be any length, and the bit-clock rate is the only limit on how many devices the chain can hold. In master mode the block makes its own frame sync by dividing the bit clock. The frame is sized for exactly four linked devices, which gives 256 bit clocks per frame. The first device of the chain drives this pulse to the other devices.

Top module: `tdm_chain_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the slot register and the master frame counter are cleared and `ser_out` and `fsync_out` are held low. After release, with no frame sync and `chain_in` held at 0, `ser_out` stays 0.
- R2: A rising bit-clock edge that sees the frame sync high loads the 64-bit slot register with `left_smp` in bits 63..32 and `right_smp` in bits 31..0.
- R3: After a load, output bits 0..31 of the frame are `left_smp[31]` down to `left_smp[0]`, and bits 32..63 are `right_smp[31]` down to `right_smp[0]`. Each bit is presented for one bit clock.
- R4: On every rising edge without a frame sync, the register shifts one place towards the MSB and takes in `chain_in`. For a load at rising edge L, output bit n (n >= 64) equals the `chain_in` value sampled at rising edge L+n-63.
- R5: The load takes priority over the shift. The `chain_in` value sampled on the loading edge is discarded and never appears on `ser_out`.
- R6: `ser_out` changes only on the falling edge of `clk`. Frame bit n appears at the falling edge that follows rising edge L+n and holds until the next falling edge. `chain_in` and the frame sync are sampled on the rising edge.
- R7: In master mode (`master_en`=1), `fsync_out` is a pulse one bit clock wide. It rises after the 256th rising edge following reset release and then repeats every 256 bit clocks.
- R8: In master mode, loads follow the internal pulse: the register loads on the rising edge where `fsync_out` is high. `fsync_in` has no effect.
- R9: In slave mode (`master_en`=0), `fsync_out` stays low and loads follow `fsync_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, shared by all devices of the chain |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1 = generate the frame sync for a four-device chain, 0 = use `fsync_in` |
| fsync_in | input | 1 | External frame-sync pulse (slave mode) |
| left_smp | input | 32 | Left sample, sent first |
| right_smp | input | 32 | Right sample, sent second |
| chain_in | input | 1 | Serial data from the upstream device's `ser_out` |
| ser_out | output | 1 | Serial data to the downstream device or the DSP |
| fsync_out | output | 1 | Generated frame-sync pulse (master mode), low in slave mode |

## Verification
A wrong slot register shows on `ser_out` within one bit clock for bits near the MSB. For bits deeper in the register, it shows up to 64 bit clocks after the load. Every output bit is therefore compared with its expected value, the samples for the first 64 bits and the delayed `chain_in` history after that. A wrong master counter first shows as a late or early `fsync_out` pulse. It also shows as a load on the wrong edge, which shifts the whole frame pattern. The bench checks the pulse on every cycle across several frames.

// File: rtl/tdm_ser_pkg.sv
// Shared constants for the chainable TDM output serializer.
// Assumes stereo slots: one left and one right sample per device.
package tdm_ser_pkg;
    localparam int unsigned DEF_SAMPLE_W  = 32;
    localparam int unsigned DEF_CHAIN_DEV = 4;

    typedef enum logic {
        SYNC_EXTERNAL = 1'b0,
        SYNC_INTERNAL = 1'b1
    } sync_src_e;
endpackage

// File: rtl/tdm_master_fsync.sv
// Master frame-sync generator: divides the bit clock by FRAME_LEN and emits
// a registered pulse one clock wide at each frame boundary.
// Assumes FRAME_LEN >= 2. The counter is held cleared while disabled.
module tdm_master_fsync #(
    parameter int unsigned FRAME_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic pulse
);
    localparam int unsigned CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count bit clocks and flag the wrap into a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            pulse <= (cnt_q == LAST);
        end
    end

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R7
    pulse_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt_q == '0));
endmodule

// File: rtl/tdm_slot_shifter.sv
// Slot register: loads a parallel word on load, otherwise shifts towards the
// MSB and takes in the serial input at the LSB. The load wins over the shift.
// Assumes WIDTH >= 2. The MSB is the serial output.
module tdm_slot_shifter #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             msb
);
    logic [WIDTH-1:0] sr_q;

    // Parallel load on frame sync, otherwise shift in the chain bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= par_in;
        else
            sr_q <= {sr_q[WIDTH-2:0], ser_in};
    end

    assign msb = sr_q[WIDTH-1];

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sr_q == $past(par_in)));
    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0])));
endmodule

// File: rtl/tdm_fall_retime.sv
// Output retimer: presents the register MSB on the falling bit-clock edge so
// the downstream device samples stable data on its rising edge.
// Assumes the synchronous reset is stable around the falling edge.
module tdm_fall_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Update the serial output on the falling edge and clear it in reset.
    always_ff @(negedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= d;
    end

    // R6
    fall_follow_chk: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/tdm_chain_serializer.sv
// Top of the chainable TDM output serializer. Chooses the frame-sync source,
// loads the stereo slot and sends it out MSB first, with the chain input
// filling the register behind it.
// Assumes clk is the shared bit clock and master_en changes only in reset.
module tdm_chain_serializer #(
    parameter int unsigned SAMPLE_W  = tdm_ser_pkg::DEF_SAMPLE_W,
    parameter int unsigned CHAIN_DEV = tdm_ser_pkg::DEF_CHAIN_DEV
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic                fsync_in,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                chain_in,
    output logic                ser_out,
    output logic                fsync_out
);
    import tdm_ser_pkg::*;

    localparam int unsigned SLOT_W    = 2 * SAMPLE_W;
    localparam int unsigned FRAME_LEN = SLOT_W * CHAIN_DEV;

    sync_src_e sync_src;
    logic      gen_pulse;
    logic      load;
    logic      sr_msb;

    // Pick the frame-sync source from the mode input.
    always_comb begin
        sync_src = master_en ? SYNC_INTERNAL : SYNC_EXTERNAL;
        load     = (sync_src == SYNC_INTERNAL) ? gen_pulse : fsync_in;
    end

    tdm_master_fsync #(.FRAME_LEN(FRAME_LEN)) fsync_gen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(master_en),
        .pulse (gen_pulse)
    );

    tdm_slot_shifter #(.WIDTH(SLOT_W)) slot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .par_in({left_smp, right_smp}),
        .ser_in(chain_in),
        .msb   (sr_msb)
    );

    tdm_fall_retime out_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sr_msb),
        .q    (ser_out)
    );

    assign fsync_out = gen_pulse;

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && $past(!master_en)) |-> !fsync_out);
    // R8
    master_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && fsync_out) |=> (sr_msb == $past(left_smp[SAMPLE_W-1])));
endmodule

// File: tb/tdm_chain_serializer_tb.sv
// Self-checking bench: sweeps slave frames with several sample patterns and
// master-mode frames, predicting every output bit arithmetically.
module tdm_chain_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic        fsync_in = 1'b0;
    logic [31:0] left_smp = '0;
    logic [31:0] right_smp = '0;
    logic        chain_in = 1'b0;
    logic        ser_out;
    logic        fsync_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int load_cyc = -1;
    logic [63:0] word_q = '0;
    logic chain_hist [0:2047];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    tdm_chain_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .fsync_in(fsync_in),
        .left_smp(left_smp), .right_smp(right_smp), .chain_in(chain_in),
        .ser_out(ser_out), .fsync_out(fsync_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int n);
        int j = n - load_cyc;
        if (j < 64) return word_q[63 - j];
        return chain_hist[n - 63];
    endfunction

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One bit clock: inputs are applied between edges, outputs checked
    // before the falling edge (previous bit) and after it (current bit).
    task automatic step(input logic fs, input logic ch, input logic loads);
        fsync_in = fs;
        chain_in = ch;
        @(posedge clk);
        cyc++;
        chain_hist[cyc] = ch;
        #5;
        if (load_cyc >= 0 && cyc - 1 >= load_cyc)
            check("R6 hold before falling edge", ser_out, exp_bit(cyc - 1));
        if (loads) begin
            load_cyc = cyc;
            word_q = {left_smp, right_smp};
        end
        #10;
        if (load_cyc >= 0) begin
            if (cyc - load_cyc < 32)      check("R3 left bit", ser_out, exp_bit(cyc));
            else if (cyc - load_cyc < 64) check("R3 right bit", ser_out, exp_bit(cyc));
            else if (cyc - load_cyc == 64) check("R5 load-edge chain bit dropped", ser_out, exp_bit(cyc));
            else                          check("R4 chain bit", ser_out, exp_bit(cyc));
        end
        if (master_en)
            check("R7 fsync_out pulse", fsync_out, (cyc % 256 == 0) && cyc > 0);
        else
            check("R9 fsync_out quiet", fsync_out, 1'b0);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        master_en = mode;
        fsync_in = 1'b1;
        chain_in = 1'b1;
        repeat (4) @(posedge clk);
        #15;
        check("R1 ser_out in reset", ser_out, 1'b0);
        check("R1 fsync_out in reset", fsync_out, 1'b0);
        rst_n = 1'b1;
        cyc = 0;
        load_cyc = -1;
    endtask

    initial begin
        logic [31:0] lpat [0:3];
        logic [31:0] rpat [0:3];
        lpat[0] = 32'h0000_0000; rpat[0] = 32'hFFFF_FFFF;
        lpat[1] = 32'hAAAA_5555; rpat[1] = 32'h8000_0001;
        lpat[2] = 32'h1234_5678; rpat[2] = 32'h9ABC_DEF0;
        lpat[3] = 32'hFFFF_FFFF; rpat[3] = 32'h0000_0000;

        // R1: cleared register shifts only zeros after release.
        do_reset(1'b0);
        for (int i = 0; i < 70; i++) begin
            step(1'b0, 1'b0, 1'b0);
            check("R1 cleared register", ser_out, 1'b0);
        end

        // R2 R3 R4 R5 R6 R9: slave frames of 128 bits, four sample patterns.
        do_reset(1'b0);
        for (int f = 0; f < 4; f++) begin
            left_smp  = lpat[f];
            right_smp = rpat[f];
            step(1'b1, 1'b1, 1'b1);        // R2 load, chain bit 1 must drop
            step(1'b0, 1'b0, 1'b0);        // R5 next chain bit differs
            for (int b = 2; b < 128; b++) begin
                step(1'b0, next_rand(), 1'b0);
                if (b == 40) begin
                    left_smp  = ~lpat[f];  // R2 inputs after load are ignored
                    right_smp = ~rpat[f];
                end
            end
        end

        // R7 R8: master mode, fsync_in toggles but must be ignored.
        do_reset(1'b1);
        left_smp  = 32'hC0FF_EE01;
        right_smp = 32'h7E57_0BB5;
        for (int i = 1; i <= 800; i++) begin
            if (i == 600) begin
                left_smp  = 32'h0F0F_A5A5;
                right_smp = 32'hF00D_1234;
            end
            step(next_rand(), next_rand(), (i % 256 == 1) && i > 256);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule